// File: doc/BRIEF.md
# Preamble-Addressed Link Controller

This block connects one local processing unit to a bank of outbound and inbound word links in a mesh of cores. The local unit hands over one payload word at a time. The controller turns each payload into a two-word frame: the node's programmed preamble word goes out first, and the payload word follows on the next cycle. Both words go to the outbound port that a route register names.

On the inbound side, each link fills its own two-word frame buffer. A round-robin arbiter takes one complete buffer per cycle. It compares the low preamble bits of that frame with two programmed values. On a local match the payload goes to the local unit. On a hop match the whole frame is sent again, unchanged, on the port that a second route register names. A frame that matches neither value is discarded and counted.

A small synchronous write port sets the two preambles and the two routes. A hop frame and a local frame can ask for the same outbound port. In that case the hop frame is sent first and the local source waits.

Top module: `plink_ctrl`

## Requirements
- R1: After synchronous active-high reset, no outbound port is valid, `loc_out_valid` is low, `drop_cnt` is zero, every `rx_ready` bit is high, and both preambles are zero. Both routes select port 0, so the first local frame goes out on port 0 with preamble word 0.
- R2: A payload is accepted in a cycle where `loc_in_valid` and `loc_in_ready` are both high. On the next cycle the routed port carries the preamble word, which is the local preamble in bits [15:0] with zeros above. On the cycle after that, the same port carries the payload word.
- R3: An outbound frame appears only on the port that the transmit route selects. Every other port stays invalid with zero data.
- R4: A write with `cfg_we` high loads one register, chosen by `cfg_addr`. Address 0 is the local preamble and address 1 is the hop preamble, each taken from `cfg_wdata[15:0]`. Address 2 is the transmit route and address 3 is the hop route, each taken from `cfg_wdata[2:0]`.
- R5: A route or preamble written while a local frame is being sent does not alter that frame. The new value first applies to the next frame.
- R6: An inbound frame is a preamble word followed by a payload word. When bits [15:0] of its preamble word equal the local preamble, the payload is presented on `loc_out_data`, with `loc_out_valid` high for one cycle. This happens two cycles after the payload word is accepted. Bits [31:16] of the preamble word are ignored. The local check takes precedence over the hop check.
- R7: An inbound frame whose preamble bits [15:0] equal the hop preamble, and not the local one, is re-sent on the hop-route port. The original preamble word, all 32 bits, goes out first, two cycles after the payload is accepted. The payload follows on the next cycle.
- R8: An inbound frame that matches neither preamble is dropped, and nothing is sent to the local unit or any outbound port. `drop_cnt` rises by one two cycles after the payload is accepted. It saturates at its maximum value (255) and never wraps.
- R9: When several inbound buffers are full, one is granted per cycle, in round-robin order starting after the last granted port. A full buffer holds its frame and keeps its `rx_ready` low until it is granted.
- R10: A hop frame and a local frame may compete for the same outbound port. The hop frame is then sent first, and `loc_in_ready` stays low until the local frame can follow without overlapping it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| loc_in_valid | input | 1 | Local payload offered |
| loc_in_data | input | 32 | Local payload word |
| loc_in_ready | output | 1 | Local payload accepted this cycle when valid |
| loc_out_valid | output | 1 | Delivered payload strobe |
| loc_out_data | output | 32 | Delivered payload word |
| rx_valid | input | 8 | Per inbound link word strobe |
| rx_data | input | 8x32 | Per inbound link word |
| rx_ready | output | 8 | Per inbound link can take a word |
| tx_valid | output | 8 | Per outbound link word strobe |
| tx_data | output | 8x32 | Per outbound link word |
| drop_cnt | output | 8 | Saturating count of discarded frames |

## Verification
A hop-through frame can claim its outbound port in the same cycle that the local unit offers a payload for that port. The bench provokes this by setting both routes to port 5. It then raises `loc_in_valid` in the exact cycle that a hop-matching inbound frame is granted. It judges the result from `loc_in_ready` in that cycle and the next, and from the four words seen on port 5: hop preamble, hop payload, local preamble, local payload, each in consecutive cycles. In a second case three inbound buffers fill on the same clock edge. There the bench judges the arbiter by the order in which their payloads reach the local output.

// File: rtl/plc_pkg.sv
package plc_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_PRE  = 2'd1,
      SEQ_PAY  = 2'd2
   } seq_e;

   localparam int CFG_LOC_PRE   = 0;
   localparam int CFG_HOP_PRE   = 1;
   localparam int CFG_TX_ROUTE  = 2;
   localparam int CFG_HOP_ROUTE = 3;
endpackage

// File: rtl/plc_rx_buf.sv
module plc_rx_buf #(
   parameter int PAY_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_valid,
   input  logic [PAY_W-1:0] rx_data,
   output logic             rx_ready,
   input  logic             take,
   output logic             full,
   output logic [PAY_W-1:0] pre_q,
   output logic [PAY_W-1:0] pay_q
);
   logic have_pre;

   assign rx_ready = !full;

   always_ff @(posedge clk) begin
      if (rst) begin
         have_pre <= 1'b0;
         full     <= 1'b0;
         pre_q    <= '0;
         pay_q    <= '0;
      end else if (take) begin
         have_pre <= 1'b0;
         full     <= 1'b0;
      end else if (rx_valid && rx_ready) begin
         if (!have_pre) begin
            pre_q    <= rx_data;
            have_pre <= 1'b1;
         end else begin
            pay_q <= rx_data;
            full  <= 1'b1;
         end
      end
   end

   AST_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
      (full && !take) |=> (full && $stable(pre_q) && $stable(pay_q))); // R9
   AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
      take |-> full); // R9
endmodule

// File: rtl/plc_rr_arb.sv
module plc_rr_arb #(
   parameter int N = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N-1:0]     req,
   input  logic             enable,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] grant_idx,
   output logic             grant_any
);
   logic [IDX_W-1:0] last_q;

   always_comb begin
      logic found;
      int   c;
      found     = 1'b0;
      grant     = '0;
      grant_idx = '0;
      c         = 0;
      for (int k = 1; k <= N; k++) begin
         c = (int'(last_q) + k) % N;
         if (!found && enable && req[c]) begin
            found     = 1'b1;
            grant[c]  = 1'b1;
            grant_idx = IDX_W'(c);
         end
      end
      grant_any = found;
   end

   always_ff @(posedge clk) begin
      if (rst) last_q <= IDX_W'(N - 1);
      else if (grant_any) last_q <= grant_idx;
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant)); // R9
   AST_GRANT_REQ: assert property (@(posedge clk) disable iff (rst)
      (grant & ~req) == '0); // R9
endmodule

// File: rtl/plc_tx_seq.sv
module plc_tx_seq
   import plc_pkg::*;
#(
   parameter int PAY_W  = 32,
   parameter int PORT_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [PORT_W-1:0] start_port,
   input  logic [PAY_W-1:0]  pre_word,
   input  logic [PAY_W-1:0]  pay_word,
   output logic              active,
   output logic              in_pre,
   output logic [PORT_W-1:0] port,
   output logic [PAY_W-1:0]  word
);
   seq_e             state;
   logic [PAY_W-1:0] pre_q;
   logic [PAY_W-1:0] pay_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SEQ_IDLE;
         port  <= '0;
         pre_q <= '0;
         pay_q <= '0;
      end else if (start) begin
         state <= SEQ_PRE;
         port  <= start_port;
         pre_q <= pre_word;
         pay_q <= pay_word;
      end else begin
         case (state)
            SEQ_PRE: state <= SEQ_PAY;
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign active = (state != SEQ_IDLE);
   assign in_pre = (state == SEQ_PRE);
   assign word   = in_pre ? pre_q : pay_q;

   AST_NO_START_IN_PRE: assert property (@(posedge clk) disable iff (rst)
      start |-> !in_pre); // R2
   AST_PAY_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
      in_pre |=> (active && !in_pre && $stable(port))); // R2
endmodule

// File: rtl/plink_ctrl.sv
module plink_ctrl
   import plc_pkg::*;
#(
   parameter int NPORT  = 8,
   parameter int PRE_W  = 16,
   parameter int PAY_W  = 32,
   parameter int CFG_AW = 4,
   parameter int CFG_DW = 16,
   parameter int CNT_W  = 8,
   localparam int PORT_W = $clog2(NPORT)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cfg_we,
   input  logic [CFG_AW-1:0]            cfg_addr,
   input  logic [CFG_DW-1:0]            cfg_wdata,
   input  logic                         loc_in_valid,
   input  logic [PAY_W-1:0]             loc_in_data,
   output logic                         loc_in_ready,
   output logic                         loc_out_valid,
   output logic [PAY_W-1:0]             loc_out_data,
   input  logic [NPORT-1:0]             rx_valid,
   input  logic [NPORT-1:0][PAY_W-1:0]  rx_data,
   output logic [NPORT-1:0]             rx_ready,
   output logic [NPORT-1:0]             tx_valid,
   output logic [NPORT-1:0][PAY_W-1:0]  tx_data,
   output logic [CNT_W-1:0]             drop_cnt
);
   // elaboration checks
   if (NPORT < 2) begin : g_bad_nport
      $error("plink_ctrl: NPORT must be at least 2");
   end
   if (PRE_W > PAY_W) begin : g_bad_prew
      $error("plink_ctrl: PRE_W must not exceed PAY_W");
   end
   if (PRE_W > CFG_DW || PORT_W > CFG_DW) begin : g_bad_cfgdw
      $error("plink_ctrl: CFG_DW too narrow for preamble or route");
   end
   if (CFG_AW < 2) begin : g_bad_cfgaw
      $error("plink_ctrl: CFG_AW must reach four registers");
   end

   // configuration registers
   logic [PRE_W-1:0]  loc_pre_r, hop_pre_r;
   logic [PORT_W-1:0] tx_route_r, hop_route_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         loc_pre_r   <= '0;
         hop_pre_r   <= '0;
         tx_route_r  <= '0;
         hop_route_r <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            CFG_AW'(CFG_LOC_PRE):   loc_pre_r   <= cfg_wdata[PRE_W-1:0];
            CFG_AW'(CFG_HOP_PRE):   hop_pre_r   <= cfg_wdata[PRE_W-1:0];
            CFG_AW'(CFG_TX_ROUTE):  tx_route_r  <= cfg_wdata[PORT_W-1:0];
            CFG_AW'(CFG_HOP_ROUTE): hop_route_r <= cfg_wdata[PORT_W-1:0];
            default: ;
         endcase
      end
   end

   // receive buffers
   logic [NPORT-1:0] buf_full, grant;
   logic [PAY_W-1:0] buf_pre [NPORT];
   logic [PAY_W-1:0] buf_pay [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_rx
      plc_rx_buf #(.PAY_W(PAY_W)) u_buf (
         .clk      (clk),
         .rst      (rst),
         .rx_valid (rx_valid[p]),
         .rx_data  (rx_data[p]),
         .rx_ready (rx_ready[p]),
         .take     (grant[p]),
         .full     (buf_full[p]),
         .pre_q    (buf_pre[p]),
         .pay_q    (buf_pay[p])
      );
   end

   // sequencer status
   logic              loc_active, loc_in_pre, hop_active, hop_in_pre;
   logic [PORT_W-1:0] loc_port, hop_port;
   logic [PAY_W-1:0]  loc_word, hop_word;

   // arbitration and preamble checks
   logic              hop_ok, grant_any;
   logic [PORT_W-1:0] grant_idx;
   logic [PAY_W-1:0]  sel_pre, sel_pay;
   logic              loc_hit, hop_hit, drop_hit;

   assign hop_ok = !hop_in_pre && !(loc_in_pre && (loc_port == hop_route_r));

   plc_rr_arb #(.N(NPORT)) u_arb (
      .clk       (clk),
      .rst       (rst),
      .req       (buf_full),
      .enable    (hop_ok),
      .grant     (grant),
      .grant_idx (grant_idx),
      .grant_any (grant_any)
   );

   assign sel_pre  = buf_pre[grant_idx];
   assign sel_pay  = buf_pay[grant_idx];
   assign loc_hit  = grant_any && (sel_pre[PRE_W-1:0] == loc_pre_r);
   assign hop_hit  = grant_any && !loc_hit && (sel_pre[PRE_W-1:0] == hop_pre_r);
   assign drop_hit = grant_any && !loc_hit && !hop_hit;

   // local transmit admission
   logic loc_block, loc_start;
   assign loc_block = (hop_in_pre && (hop_port == tx_route_r)) ||
                      (hop_hit && (hop_route_r == tx_route_r));
   assign loc_in_ready = !loc_in_pre && !loc_block;
   assign loc_start    = loc_in_valid && loc_in_ready;

   plc_tx_seq #(.PAY_W(PAY_W), .PORT_W(PORT_W)) u_loc_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (loc_start),
      .start_port (tx_route_r),
      .pre_word   ({{(PAY_W-PRE_W){1'b0}}, loc_pre_r}),
      .pay_word   (loc_in_data),
      .active     (loc_active),
      .in_pre     (loc_in_pre),
      .port       (loc_port),
      .word       (loc_word)
   );

   plc_tx_seq #(.PAY_W(PAY_W), .PORT_W(PORT_W)) u_hop_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (hop_hit),
      .start_port (hop_route_r),
      .pre_word   (sel_pre),
      .pay_word   (sel_pay),
      .active     (hop_active),
      .in_pre     (hop_in_pre),
      .port       (hop_port),
      .word       (hop_word)
   );

   // outbound port steering, hop frames first
   for (genvar p = 0; p < NPORT; p++) begin : g_tx
      always_comb begin
         if (hop_active && (hop_port == PORT_W'(p))) begin
            tx_valid[p] = 1'b1;
            tx_data[p]  = hop_word;
         end else if (loc_active && (loc_port == PORT_W'(p))) begin
            tx_valid[p] = 1'b1;
            tx_data[p]  = loc_word;
         end else begin
            tx_valid[p] = 1'b0;
            tx_data[p]  = '0;
         end
      end
   end

   // local delivery and drop counting
   always_ff @(posedge clk) begin
      if (rst) begin
         loc_out_valid <= 1'b0;
         loc_out_data  <= '0;
         drop_cnt      <= '0;
      end else begin
         loc_out_valid <= loc_hit;
         if (loc_hit) loc_out_data <= sel_pay;
         if (drop_hit && (drop_cnt != '1)) drop_cnt <= drop_cnt + 1'b1;
      end
   end

   AST_RST_QUIET: assert property (@(posedge clk)
      rst |=> (tx_valid == '0 && !loc_out_valid && drop_cnt == '0)); // R1
   AST_TX_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
      !(hop_active && loc_active && (hop_port == loc_port))); // R10
   AST_TX_BOUND: assert property (@(posedge clk) disable iff (rst)
      $countones(tx_valid) <= 2); // R3
   AST_DROP_MONO: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (drop_cnt >= $past(drop_cnt))); // R8
   AST_LOC_ROUTE_HELD: assert property (@(posedge clk) disable iff (rst)
      loc_in_pre |=> (loc_port == $past(loc_port))); // R5
endmodule

// File: tb/plink_ctrl_tb_top.sv
module plink_ctrl_tb_top;
   localparam int NP = 8;
   localparam int PW = 32;

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    cfg_we = 1'b0;
   logic [3:0]              cfg_addr = '0;
   logic [15:0]             cfg_wdata = '0;
   logic                    loc_in_valid = 1'b0;
   logic [PW-1:0]           loc_in_data = '0;
   logic                    loc_in_ready;
   logic                    loc_out_valid;
   logic [PW-1:0]           loc_out_data;
   logic [NP-1:0]           rx_valid = '0;
   logic [NP-1:0][PW-1:0]   rx_data = '0;
   logic [NP-1:0]           rx_ready;
   logic [NP-1:0]           tx_valid;
   logic [NP-1:0][PW-1:0]   tx_data;
   logic [7:0]              drop_cnt;

   int n_chk  = 0;
   int n_fail = 0;
   int exp_drop = 0;

   always #4 clk = ~clk;

   plink_ctrl dut_i (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .loc_in_valid(loc_in_valid), .loc_in_data(loc_in_data), .loc_in_ready(loc_in_ready),
      .loc_out_valid(loc_out_valid), .loc_out_data(loc_out_data),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .drop_cnt(drop_cnt)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
      chk(act === exp, req, act, exp);
   endtask

   task automatic cfg_write(input int a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // returns at the negedge of the grant cycle
   task automatic rx_send(input int p, input logic [PW-1:0] pre, input logic [PW-1:0] pay);
      @(negedge clk);
      rx_valid[p] = 1'b1; rx_data[p] = pre;
      @(negedge clk);
      rx_data[p] = pay;
      @(negedge clk);
      rx_valid[p] = 1'b0;
   endtask

   // returns at the negedge where the preamble word is visible
   task automatic loc_send(input logic [PW-1:0] pay);
      @(negedge clk);
      loc_in_valid = 1'b1; loc_in_data = pay;
      @(negedge clk);
      loc_in_valid = 1'b0;
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // pre word, payload, class (0 local, 1 hop, 2 drop)
   localparam logic [65:0] VEC [0:5] = '{
      {32'h0000_1234, 32'hA000_0001, 2'd0},
      {32'h0000_BEEF, 32'hA000_0002, 2'd1},
      {32'h0000_5A5A, 32'hA000_0003, 2'd2},
      {32'hFFFF_1234, 32'hA000_0004, 2'd0},
      {32'h7777_BEEF, 32'hA000_0005, 2'd1},
      {32'h0000_1235, 32'hA000_0006, 2'd2}
   };

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk_eq("R1 tx_valid", 64'(tx_valid), 0);
      chk_eq("R1 loc_out_valid", 64'(loc_out_valid), 0);
      chk_eq("R1 drop_cnt", 64'(drop_cnt), 0);
      chk_eq("R1 rx_ready", 64'(rx_ready), 64'hFF);
      chk_eq("R1 loc_in_ready", 64'(loc_in_ready), 1);
      loc_send(32'hCAFE_0001);
      chk_eq("R1 default port", 64'(tx_valid), 64'h01);
      chk_eq("R1 default preamble", 64'(tx_data[0]), 0);
      @(negedge clk);

      // R4 configuration
      cfg_write(0, 16'h1234);
      cfg_write(1, 16'hBEEF);
      cfg_write(2, 16'h0001);
      cfg_write(3, 16'h0005);

      // R2 / R3 local transmit
      loc_send(32'h1111_2222);
      chk_eq("R2 preamble word", 64'(tx_data[1]), 64'h1234);
      chk_eq("R3 only routed port", 64'(tx_valid), 64'h02);
      @(negedge clk);
      chk_eq("R2 payload word", 64'(tx_data[1]), 64'h1111_2222);
      chk_eq("R3 payload port", 64'(tx_valid), 64'h02);
      @(negedge clk);
      chk_eq("R2 frame ends", 64'(tx_valid), 0);

      // R6 R7 R8 vector table
      for (int i = 0; i < 6; i++) begin
         logic [31:0] vp, vd;
         logic [1:0]  vc;
         {vp, vd, vc} = VEC[i];
         rx_send(i, vp, vd);
         @(negedge clk);
         case (vc)
            2'd0: begin
               chk_eq("R6 deliver valid", 64'(loc_out_valid), 1);
               chk_eq("R6 deliver data", 64'(loc_out_data), 64'(vd));
               chk_eq("R6 no transmit", 64'(tx_valid), 0);
            end
            2'd1: begin
               chk_eq("R7 hop port", 64'(tx_valid), 64'h20);
               chk_eq("R7 hop preamble unchanged", 64'(tx_data[5]), 64'(vp));
               chk_eq("R7 not delivered", 64'(loc_out_valid), 0);
               @(negedge clk);
               chk_eq("R7 hop payload", 64'(tx_data[5]), 64'(vd));
            end
            default: begin
               exp_drop++;
               chk_eq("R8 drop count", 64'(drop_cnt), 64'(exp_drop));
               chk_eq("R8 no transmit", 64'(tx_valid), 0);
               chk_eq("R8 not delivered", 64'(loc_out_valid), 0);
            end
         endcase
         @(negedge clk);
      end

      // R9 round robin: last grant on port 4, then 1, 4, 6 together
      rx_send(4, 32'h1234, 32'hB000_0000);
      @(negedge clk);
      @(negedge clk);
      rx_valid[1] = 1'b1; rx_valid[4] = 1'b1; rx_valid[6] = 1'b1;
      rx_data[1] = 32'h1234; rx_data[4] = 32'h1234; rx_data[6] = 32'h1234;
      @(negedge clk);
      rx_data[1] = 32'hB000_0001; rx_data[4] = 32'hB000_0004; rx_data[6] = 32'hB000_0006;
      @(negedge clk);
      rx_valid = '0;
      chk_eq("R9 held port 1 not ready", 64'(rx_ready[1]), 0);
      chk_eq("R9 held port 4 not ready", 64'(rx_ready[4]), 0);
      @(negedge clk);
      chk_eq("R9 first grant port 6", 64'(loc_out_data), 64'hB000_0006);
      @(negedge clk);
      chk_eq("R9 second grant port 1", 64'(loc_out_data), 64'hB000_0001);
      @(negedge clk);
      chk_eq("R9 third grant port 4", 64'(loc_out_data), 64'hB000_0004);
      chk_eq("R9 third valid", 64'(loc_out_valid), 1);
      @(negedge clk);

      // R10 hop and local on the same port
      cfg_write(2, 16'h0005);
      rx_send(2, 32'h0000_BEEF, 32'hC000_0002);
      loc_in_valid = 1'b1; loc_in_data = 32'hD00D_0001;
      #1;
      chk_eq("R10 local stalled at hop grant", 64'(loc_in_ready), 0);
      @(negedge clk);
      chk_eq("R10 hop preamble first", 64'(tx_data[5]), 64'hBEEF);
      chk_eq("R10 still stalled", 64'(loc_in_ready), 0);
      @(negedge clk);
      chk_eq("R10 hop payload", 64'(tx_data[5]), 64'hC000_0002);
      chk_eq("R10 local released", 64'(loc_in_ready), 1);
      @(negedge clk);
      loc_in_valid = 1'b0;
      chk_eq("R10 local preamble follows", 64'(tx_data[5]), 64'h1234);
      @(negedge clk);
      chk_eq("R10 local payload", 64'(tx_data[5]), 64'hD00D_0001);
      chk_eq("R10 port 5 only", 64'(tx_valid), 64'h20);
      @(negedge clk);

      // R5 write during a frame
      cfg_write(2, 16'h0002);
      loc_send(32'hE000_0001);
      cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = 16'h0007;
      chk_eq("R5 preamble on old route", 64'(tx_valid), 64'h04);
      @(negedge clk);
      cfg_addr = 4'd0; cfg_wdata = 16'h5555;
      chk_eq("R5 payload on old route", 64'(tx_valid), 64'h04);
      chk_eq("R5 payload data", 64'(tx_data[2]), 64'hE000_0001);
      @(negedge clk);
      cfg_we = 1'b0;
      loc_send(32'hE000_0002);
      chk_eq("R5 next frame new route", 64'(tx_valid), 64'h80);
      chk_eq("R5 next frame new preamble", 64'(tx_data[7]), 64'h5555);
      @(negedge clk);

      // R8 saturation
      for (int k = 0; k < 260; k++) begin
         rx_send(7, 32'h0000_0F0F, 32'(k));
         @(negedge clk);
         exp_drop = (exp_drop < 255) ? exp_drop + 1 : 255;
         if (k == 100) chk_eq("R8 drop count midway", 64'(drop_cnt), 64'(exp_drop));
      end
      chk_eq("R8 drop count saturates", 64'(drop_cnt), 255);

      // R1 reset mid-run
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk_eq("R1 drop cleared", 64'(drop_cnt), 0);
      loc_send(32'hF000_0001);
      chk_eq("R1 route back to port 0", 64'(tx_valid), 64'h01);
      chk_eq("R1 preamble back to zero", 64'(tx_data[0]), 0);
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule